// File: doc/BRIEF.md
# Superscalar Register Rename Stage

This block renames a group of up to four decoded instructions in one clock. Each instruction names one destination and two source architectural registers. Sources are translated through a map table into physical register tags, and each source carries a ready bit. Every valid destination receives a fresh physical register taken from a free list. When a later instruction in the group reads a register that an earlier instruction in the same group writes, the map table lookup is overridden by the earlier writer's new tag. The previous mapping of each destination is also produced, so that the commit logic can free it once the instruction retires.

All rename results are combinational on the current group and the current table state. The map table, ready bits and free list are updated at the next rising edge, and only when the whole group is accepted. If the free list cannot supply a register for every valid slot, the whole group stalls and no state changes. A writeback port marks physical registers ready, and a commit port pushes freed registers onto the tail of the free list.

Top module: `rn_rename_top`

## Requirements
- R1: After reset, architectural register a maps to physical register a, and physical registers below the architectural count are ready.
- R2: A source with no earlier valid writer in the group outputs the map table's tag for that register, with ready equal to that register's ready bit, or to 1 if it matches a same-cycle writeback.
- R3: Valid slots receive distinct new destination tags taken from the free list head in slot order, skipping invalid slots. After reset the free list holds the registers from the architectural count up to the top register, in ascending order.
- R4: A source that matches the destination of an earlier valid slot in the group outputs the new tag of the nearest such slot, and its ready bit is 0.
- R5: The old-tag output of a slot is the new tag of the nearest earlier valid slot with the same destination, or else the map table entry of that destination.
- R6: After an accepted group, each written architectural register maps to the new tag of the last slot in the group that writes it.
- R7: The group stalls (stall output 1) exactly when the number of valid slots exceeds the free registers. A stalled group changes neither the map table nor the free list.
- R8: A writeback sets the ready bit of its physical register from the next cycle on. A source whose tag matches a writeback in the same cycle is reported ready.
- R9: Registers returned on the commit port are appended to the free list tail in slot order, skipping invalid commit slots, and are handed out after the registers already in the list.
- R10: A newly allocated destination register reads as not ready until it is written back.
- R11: Invalid slots allocate nothing, change no mapping and do not override later slots' sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | W | Valid bit per slot |
| in_dst | input | W x AW | Destination architectural register per slot |
| in_src_a | input | W x AW | First source architectural register per slot |
| in_src_b | input | W x AW | Second source architectural register per slot |
| wb_valid | input | WB | Writeback valid per port |
| wb_tag | input | WB x PW | Physical register being written back |
| cm_valid | input | W | Commit free valid per slot |
| cm_tag | input | W x PW | Physical register freed by commit |
| out_stall | output | 1 | Group cannot be renamed this cycle |
| out_src_a_tag | output | W x PW | Physical tag of first source |
| out_src_b_tag | output | W x PW | Physical tag of second source |
| out_src_a_rdy | output | W | First source ready |
| out_src_b_rdy | output | W | Second source ready |
| out_dst_tag | output | W x PW | Newly allocated destination tag |
| out_old_tag | output | W x PW | Previous mapping of the destination |

## Verification
Every rename output and the stall flag belong to the same cycle as the group that produces them. The bench applies each group on the falling edge and compares 5 ns later, a quarter period before the rising edge that commits the state. Table updates, writebacks and commit returns take effect at that rising edge. Their effect is checked in the outputs of the following group, so each check looks exactly one edge after the stimulus that caused it.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // Number of set bits of a mask that lie strictly below position n.
  function automatic int unsigned ones_below(input logic [15:0] m, input int n);
    int unsigned c;
    c = 0;
    for (int j = 0; j < 16; j++)
      if (j < n && m[j]) c = c + 1;
    return c;
  endfunction
endpackage

// File: rtl/rn_dep_check.sv
module rn_dep_check #(
  parameter int unsigned W  = 4,
  parameter int unsigned AW = 5,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]          in_valid,
  input  logic [W-1:0][AW-1:0]  in_dst,
  input  logic [W-1:0][AW-1:0]  in_src_a,
  input  logic [W-1:0][AW-1:0]  in_src_b,
  output logic [W-1:0]          a_hit,
  output logic [W-1:0][IW-1:0]  a_idx,
  output logic [W-1:0]          b_hit,
  output logic [W-1:0][IW-1:0]  b_idx,
  output logic [W-1:0]          o_hit,
  output logic [W-1:0][IW-1:0]  o_idx
);
  // Scan earlier slots in order; the last match is the nearest writer.
  function automatic logic [IW:0] nearest_writer(input int slot, input logic [AW-1:0] r,
                                                 input logic [W-1:0] v,
                                                 input logic [W-1:0][AW-1:0] d);
    logic [IW:0] res;
    res = '0;
    for (int j = 0; j < W; j++)
      if (j < slot && v[j] && d[j] == r) res = {1'b1, IW'(j)};
    return res;
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_slot
    assign {a_hit[i], a_idx[i]} = nearest_writer(i, in_src_a[i], in_valid, in_dst);
    assign {b_hit[i], b_idx[i]} = nearest_writer(i, in_src_b[i], in_valid, in_dst);
    assign {o_hit[i], o_idx[i]} = nearest_writer(i, in_dst[i],   in_valid, in_dst);
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned W         = 4,
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned INIT_BASE = 32,
  parameter int unsigned INIT_CNT  = 32,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned NW = $clog2(DEPTH + 1),
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pop_go,
  input  logic [CW-1:0]        pop_n,
  input  logic [W-1:0]         ret_valid,
  input  logic [W-1:0][PW-1:0] ret_tag,
  output logic [W-1:0][PW-1:0] peek,
  output logic [NW-1:0]        avail
);
  logic [PW-1:0]         mem_q [DEPTH];
  logic [PW-1:0]         head_q, tail_q;
  logic [NW-1:0]         cnt_q;
  logic [W-1:0][PW-1:0]  wr_pos;
  logic [CW-1:0]         ret_n;

  always_comb begin
    ret_n = '0;
    for (int k = 0; k < W; k++) begin
      wr_pos[k] = tail_q + PW'(ret_n);
      ret_n     = ret_n + CW'(ret_valid[k]);
    end
    for (int k = 0; k < W; k++) peek[k] = mem_q[head_q + PW'(k)];
  end

  assign avail = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= PW'(INIT_BASE + k);
      head_q <= '0;
      tail_q <= PW'(INIT_CNT);
      cnt_q  <= NW'(INIT_CNT);
    end else begin
      for (int k = 0; k < W; k++)
        if (ret_valid[k]) mem_q[wr_pos[k]] <= ret_tag[k];
      if (pop_go) head_q <= head_q + PW'(pop_n);
      tail_q <= tail_q + PW'(ret_n);
      cnt_q  <= cnt_q - (pop_go ? NW'(pop_n) : NW'(0)) + NW'(ret_n);
    end
  end

  AST_FL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_go |-> (NW'(pop_n) <= cnt_q)); // R7
  AST_FL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NW'(DEPTH)); // R9
endmodule

// File: rtl/rn_ready_table.sv
module rn_ready_table #(
  parameter int unsigned PHYS = 64,
  parameter int unsigned ARCH = 32,
  parameter int unsigned W    = 4,
  parameter int unsigned WB   = 2,
  parameter int unsigned NQ   = 8,
  localparam int unsigned PW  = $clog2(PHYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WB-1:0]         wb_valid,
  input  logic [WB-1:0][PW-1:0] wb_tag,
  input  logic [W-1:0]          clr_valid,
  input  logic [W-1:0][PW-1:0]  clr_tag,
  input  logic [NQ-1:0][PW-1:0] q_tag,
  output logic [NQ-1:0]         q_rdy
);
  logic [PHYS-1:0] rdy_q, rdy_d;
  logic [WB-1:0]   wb_cleared;

  function automatic logic wb_match(input logic [PW-1:0] t, input logic [WB-1:0] v,
                                    input logic [WB-1:0][PW-1:0] g);
    logic m;
    m = 1'b0;
    for (int k = 0; k < WB; k++) if (v[k] && g[k] == t) m = 1'b1;
    return m;
  endfunction

  always_comb begin
    for (int n = 0; n < NQ; n++)
      q_rdy[n] = rdy_q[q_tag[n]] | wb_match(q_tag[n], wb_valid, wb_tag);
    rdy_d = rdy_q;
    for (int k = 0; k < WB; k++) if (wb_valid[k]) rdy_d[wb_tag[k]] = 1'b1;
    for (int k = 0; k < W; k++)  if (clr_valid[k]) rdy_d[clr_tag[k]] = 1'b0;
    for (int k = 0; k < WB; k++) begin
      wb_cleared[k] = 1'b0;
      for (int j = 0; j < W; j++)
        if (clr_valid[j] && clr_tag[j] == wb_tag[k]) wb_cleared[k] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PHYS; p++) rdy_q[p] <= (p < ARCH);
    end else begin
      rdy_q <= rdy_d;
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_clr_chk
    AST_ALLOC_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_valid[k] |=> !rdy_q[$past(clr_tag[k])]); // R10
  end
  for (genvar k = 0; k < WB; k++) begin : g_wb_chk
    AST_WB_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid[k] && !wb_cleared[k]) |=> rdy_q[$past(wb_tag[k])]); // R8
  end
endmodule

// File: rtl/rn_rename_top.sv
module rn_rename_top #(
  parameter int unsigned W    = 4,
  parameter int unsigned ARCH = 32,
  parameter int unsigned PHYS = 64,
  parameter int unsigned WB   = 2,
  localparam int unsigned AW = $clog2(ARCH),
  localparam int unsigned PW = $clog2(PHYS),
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1,
  localparam int unsigned CW = $clog2(W + 1),
  localparam int unsigned NW = $clog2(PHYS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [W-1:0]          in_valid,
  input  logic [W-1:0][AW-1:0]  in_dst,
  input  logic [W-1:0][AW-1:0]  in_src_a,
  input  logic [W-1:0][AW-1:0]  in_src_b,
  input  logic [WB-1:0]         wb_valid,
  input  logic [WB-1:0][PW-1:0] wb_tag,
  input  logic [W-1:0]          cm_valid,
  input  logic [W-1:0][PW-1:0]  cm_tag,
  output logic                  out_stall,
  output logic [W-1:0][PW-1:0]  out_src_a_tag,
  output logic [W-1:0][PW-1:0]  out_src_b_tag,
  output logic [W-1:0]          out_src_a_rdy,
  output logic [W-1:0]          out_src_b_rdy,
  output logic [W-1:0][PW-1:0]  out_dst_tag,
  output logic [W-1:0][PW-1:0]  out_old_tag
);
  import rn_pkg::*;

  logic [ARCH-1:0][PW-1:0] map_q;
  logic [CW-1:0]           need;
  logic                    fire;
  logic [W-1:0][CW-1:0]    slot_pos;
  logic [W-1:0][PW-1:0]    new_tag;
  logic [W-1:0][PW-1:0]    peek;
  logic [NW-1:0]           avail;
  logic [W-1:0]            a_hit, b_hit, o_hit;
  logic [W-1:0][IW-1:0]    a_idx, b_idx, o_idx;
  logic [2*W-1:0][PW-1:0]  q_tag;
  logic [2*W-1:0]          q_rdy;
  logic [W-1:0]            clr_valid;
  logic                    dst_collide;

  rn_dep_check #(.W(W), .AW(AW)) u_dep (
    .in_valid(in_valid), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .a_hit(a_hit), .a_idx(a_idx), .b_hit(b_hit), .b_idx(b_idx),
    .o_hit(o_hit), .o_idx(o_idx));

  rn_free_list #(.W(W), .DEPTH(PHYS), .INIT_BASE(ARCH), .INIT_CNT(PHYS - ARCH)) u_fl (
    .clk(clk), .rst_n(rst_n), .pop_go(fire), .pop_n(need),
    .ret_valid(cm_valid), .ret_tag(cm_tag), .peek(peek), .avail(avail));

  rn_ready_table #(.PHYS(PHYS), .ARCH(ARCH), .W(W), .WB(WB), .NQ(2*W)) u_rdy (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .clr_valid(clr_valid), .clr_tag(new_tag), .q_tag(q_tag), .q_rdy(q_rdy));

  always_comb begin
    need      = CW'(ones_below(16'(in_valid), W));
    out_stall = NW'(need) > avail;
    fire      = !out_stall;
    for (int i = 0; i < W; i++) begin
      slot_pos[i]     = CW'(ones_below(16'(in_valid), i));
      new_tag[i]      = peek[IW'(slot_pos[i])];
      q_tag[2*i]      = map_q[in_src_a[i]];
      q_tag[2*i+1]    = map_q[in_src_b[i]];
      out_src_a_tag[i] = a_hit[i] ? new_tag[a_idx[i]] : q_tag[2*i];
      out_src_b_tag[i] = b_hit[i] ? new_tag[b_idx[i]] : q_tag[2*i+1];
      out_src_a_rdy[i] = a_hit[i] ? 1'b0 : q_rdy[2*i];
      out_src_b_rdy[i] = b_hit[i] ? 1'b0 : q_rdy[2*i+1];
      out_old_tag[i]   = o_hit[i] ? new_tag[o_idx[i]] : map_q[in_dst[i]];
      out_dst_tag[i]   = new_tag[i];
      clr_valid[i]     = fire && in_valid[i];
    end
    dst_collide = 1'b0;
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++)
        if (i < j && in_valid[i] && in_valid[j] && new_tag[i] == new_tag[j]) dst_collide = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ARCH; r++) map_q[r] <= PW'(r);
    end else if (fire) begin
      for (int i = 0; i < W; i++)
        if (in_valid[i]) map_q[in_dst[i]] <= new_tag[i];
    end
  end

  AST_DST_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !dst_collide); // R3
  AST_STALL_FREEZES_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_stall |=> $stable(map_q)); // R7
endmodule

// File: tb/sim_rn_rename_top.sv
module sim_rn_rename_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]      in_valid;
  logic [3:0][4:0] in_dst, in_src_a, in_src_b;
  logic [1:0]      wb_valid;
  logic [1:0][5:0] wb_tag;
  logic [3:0]      cm_valid;
  logic [3:0][5:0] cm_tag;
  logic            out_stall;
  logic [3:0][5:0] out_src_a_tag, out_src_b_tag, out_dst_tag, out_old_tag;
  logic [3:0]      out_src_a_rdy, out_src_b_rdy;

  rn_rename_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .cm_valid(cm_valid), .cm_tag(cm_tag), .out_stall(out_stall),
    .out_src_a_tag(out_src_a_tag), .out_src_b_tag(out_src_b_tag),
    .out_src_a_rdy(out_src_a_rdy), .out_src_b_rdy(out_src_b_rdy),
    .out_dst_tag(out_dst_tag), .out_old_tag(out_old_tag));

  typedef struct packed {
    logic            stall;
    logic [3:0]      v;
    logic [3:0][5:0] a_tag, b_tag, dst, old;
    logic [3:0]      a_rdy, b_rdy, a_ovr, b_ovr;
  } exp_t;

  exp_t  sbq[$];
  string lblq[$];
  event  samp_ev;
  int    total = 0;
  int    bad = 0;

  int  mdl_map[32];
  bit  mdl_rdy[64];
  int  mdl_fq[$];

  logic [3:0] g_v, g_cmv;
  logic [1:0] g_wbv;
  int g_dst[4], g_sa[4], g_sb[4], g_wbt[2], g_cmt[4];

  task automatic chk(input string lbl, input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s [%s] %s: got %0d exp %0d", req, lbl, what, got, exp);
    end
  endtask

  task automatic clr_in();
    g_v = '0; g_wbv = '0; g_cmv = '0;
    for (int i = 0; i < 4; i++) begin g_dst[i] = 0; g_sa[i] = 0; g_sb[i] = 0; g_cmt[i] = 0; end
    for (int k = 0; k < 2; k++) g_wbt[k] = 0;
  endtask

  function automatic bit wb_hit(input int t);
    bit h = 0;
    for (int k = 0; k < 2; k++) if (g_wbv[k] && g_wbt[k] == t) h = 1;
    return h;
  endfunction

  // Driver: apply group, predict results, push to scoreboard, advance model.
  task automatic step(input string lbl);
    exp_t e;
    int nt[4];
    int nv, k, ia, ib, io;
    @(negedge clk);
    in_valid = g_v; wb_valid = g_wbv; cm_valid = g_cmv;
    for (int i = 0; i < 4; i++) begin
      in_dst[i] = 5'(g_dst[i]); in_src_a[i] = 5'(g_sa[i]); in_src_b[i] = 5'(g_sb[i]);
      cm_tag[i] = 6'(g_cmt[i]);
    end
    for (int j = 0; j < 2; j++) wb_tag[j] = 6'(g_wbt[j]);
    e = '0;
    nv = 0;
    for (int i = 0; i < 4; i++) if (g_v[i]) nv++;
    e.stall = (nv > mdl_fq.size());
    e.v = g_v;
    k = 0;
    for (int i = 0; i < 4; i++) begin
      nt[i] = 0;
      if (g_v[i] && k < mdl_fq.size()) begin nt[i] = mdl_fq[k]; k++; end
    end
    for (int i = 0; i < 4; i++) begin
      ia = -1; ib = -1; io = -1;
      for (int j = 0; j < i; j++) if (g_v[j]) begin
        if (g_dst[j] == g_sa[i]) ia = j;
        if (g_dst[j] == g_sb[i]) ib = j;
        if (g_dst[j] == g_dst[i]) io = j;
      end
      e.a_ovr[i] = (ia >= 0);
      e.b_ovr[i] = (ib >= 0);
      e.a_tag[i] = 6'((ia >= 0) ? nt[ia] : mdl_map[g_sa[i]]);
      e.b_tag[i] = 6'((ib >= 0) ? nt[ib] : mdl_map[g_sb[i]]);
      e.a_rdy[i] = (ia >= 0) ? 1'b0 : (mdl_rdy[mdl_map[g_sa[i]]] || wb_hit(mdl_map[g_sa[i]]));
      e.b_rdy[i] = (ib >= 0) ? 1'b0 : (mdl_rdy[mdl_map[g_sb[i]]] || wb_hit(mdl_map[g_sb[i]]));
      e.old[i]   = 6'((io >= 0) ? nt[io] : mdl_map[g_dst[i]]);
      e.dst[i]   = 6'(nt[i]);
    end
    sbq.push_back(e);
    lblq.push_back(lbl);
    for (int j = 0; j < 2; j++) if (g_wbv[j]) mdl_rdy[g_wbt[j]] = 1;
    if (!e.stall) begin
      for (int i = 0; i < 4; i++) if (g_v[i]) begin
        mdl_map[g_dst[i]] = nt[i];
        mdl_rdy[nt[i]] = 0;
      end
      for (int i = 0; i < nv; i++) void'(mdl_fq.pop_front());
    end
    for (int i = 0; i < 4; i++) if (g_cmv[i]) mdl_fq.push_back(g_cmt[i]);
    #5;
    -> samp_ev;
  endtask

  // Monitor: pop expected item and compare with the outputs.
  initial begin
    exp_t e;
    string l;
    forever begin
      @(samp_ev);
      e = sbq.pop_front();
      l = lblq.pop_front();
      chk(l, "R7", "stall", int'(out_stall), int'(e.stall));
      if (!e.stall) begin
        for (int i = 0; i < 4; i++) if (e.v[i]) begin
          chk(l, e.a_ovr[i] ? "R4" : "R2", $sformatf("slot %0d src_a tag", i), int'(out_src_a_tag[i]), int'(e.a_tag[i]));
          chk(l, e.b_ovr[i] ? "R4" : "R2", $sformatf("slot %0d src_b tag", i), int'(out_src_b_tag[i]), int'(e.b_tag[i]));
          chk(l, e.a_ovr[i] ? "R4" : "R8", $sformatf("slot %0d src_a rdy", i), int'(out_src_a_rdy[i]), int'(e.a_rdy[i]));
          chk(l, e.b_ovr[i] ? "R4" : "R8", $sformatf("slot %0d src_b rdy", i), int'(out_src_b_rdy[i]), int'(e.b_rdy[i]));
          chk(l, "R3", $sformatf("slot %0d dst tag", i), int'(out_dst_tag[i]), int'(e.dst[i]));
          chk(l, "R5", $sformatf("slot %0d old tag", i), int'(out_old_tag[i]), int'(e.old[i]));
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog: got hang exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    in_valid = '0; in_dst = '0; in_src_a = '0; in_src_b = '0;
    wb_valid = '0; wb_tag = '0; cm_valid = '0; cm_tag = '0;
    for (int a = 0; a < 32; a++) mdl_map[a] = a;
    for (int p = 0; p < 64; p++) mdl_rdy[p] = (p < 32);
    for (int p = 32; p < 64; p++) mdl_fq.push_back(p);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: identity mapping, all architectural registers ready
    clr_in(); g_v = 4'b1111;
    for (int i = 0; i < 4; i++) begin g_dst[i] = i + 1; g_sa[i] = 10 + i; g_sb[i] = 20 + i; end
    step("R1");
    // R6 R10: sources read previous group's writers, not ready
    clr_in(); g_v = 4'b1111;
    for (int i = 0; i < 4; i++) begin g_dst[i] = 5 + i; g_sa[i] = i + 1; g_sb[i] = 30; end
    step("R6 R10");
    // R4 R5: in-group chain with repeated writers
    clr_in(); g_v = 4'b1111;
    g_dst[0] = 3; g_sa[0] = 1; g_sb[0] = 2;
    g_dst[1] = 4; g_sa[1] = 3; g_sb[1] = 5;
    g_dst[2] = 3; g_sa[2] = 4; g_sb[2] = 3;
    g_dst[3] = 9; g_sa[3] = 3; g_sb[3] = 4;
    step("R4 R5");
    // R6: last writer in group wins
    clr_in(); g_v = 4'b0001; g_dst[0] = 15; g_sa[0] = 3; g_sb[0] = 4;
    step("R6");
    // R11: invalid slots skipped for allocation and override
    clr_in(); g_v = 4'b0101;
    g_dst[0] = 16; g_sa[0] = 9;
    g_dst[1] = 12; g_sa[1] = 1;
    g_dst[2] = 17; g_sa[2] = 12; g_sb[2] = 16;
    g_dst[3] = 18;
    step("R11");
    clr_in(); g_v = 4'b0001; g_dst[0] = 19; g_sa[0] = 12; g_sb[0] = 17;
    step("R11");
    // R8: same-cycle writeback bypass and later ready
    clr_in(); g_v = 4'b0011;
    g_dst[0] = 20; g_sa[0] = 3; g_sb[0] = 5;
    g_dst[1] = 21; g_sa[1] = 4; g_sb[1] = 6;
    g_wbv = 2'b11; g_wbt[0] = mdl_map[3]; g_wbt[1] = mdl_map[5];
    step("R8");
    clr_in(); g_v = 4'b0011;
    g_dst[0] = 22; g_sa[0] = 3; g_sb[0] = 5;
    g_dst[1] = 23; g_sa[1] = 4; g_sb[1] = 20;
    step("R8");
    // R3: drain the free list
    while (mdl_fq.size() >= 4) begin
      clr_in(); g_v = 4'b1111;
      for (int i = 0; i < 4; i++) begin g_dst[i] = 24 + i; g_sa[i] = 20 + i; g_sb[i] = 24 + i; end
      step("R3");
    end
    // R7: one more than available stalls, exactly available proceeds
    r = mdl_fq.size();
    clr_in(); g_v = 4'((1 << (r + 1)) - 1);
    for (int i = 0; i < 4; i++) begin g_dst[i] = 1 + i; g_sa[i] = 1 + i; g_sb[i] = 2; end
    step("R7");
    clr_in(); g_v = 4'((1 << r) - 1);
    for (int i = 0; i < 4; i++) begin g_dst[i] = 28 + i; g_sa[i] = 1 + i; g_sb[i] = 3; end
    step("R7");
    clr_in(); g_v = 4'b0001; g_dst[0] = 1; g_sa[0] = 2;
    step("R7");
    // R9: commit returns appended in slot order, invalid commit slots skipped
    clr_in(); g_cmv = 4'b1011;
    g_cmt[0] = 7; g_cmt[1] = 8; g_cmt[2] = 9; g_cmt[3] = 10;
    step("R9");
    clr_in(); g_cmv = 4'b0001; g_cmt[0] = 1;
    step("R9");
    clr_in(); g_v = 4'b1111;
    for (int i = 0; i < 4; i++) begin g_dst[i] = 2 + i; g_sa[i] = 28 + i; g_sb[i] = 2 + i; end
    step("R9");
    clr_in(); g_v = 4'b0001; g_dst[0] = 6; g_sa[0] = 2;
    step("R9 R7");
    clr_in();
    step("R6");
    #20;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule